// File: doc/BRIEF.md
# Dithered Half-Period PWM Generator

This block drives one PWM output from an 11-bit period word and an 11-bit duty word. It is meant to sit behind a register file that supplies those words, together with a channel enable and a dither enable. A shared up-counter provides the timebase. A compare against that counter sets the output high, and the counter's wrap clears it again.

With dithering off, one counter run is one PWM period, and the output rises when the counter reaches the full duty word. With dithering on, each period is split into two runs of half the period length. The first run compares against the upper ten duty bits. In the second run the duty word's low bit adds one count to that compare value. The average high time therefore resolves to a half count, and for any duty between the extremes the output shows four edges per period.

Period, duty and dither mode are copied into shadow registers when a full period ends. A new setting therefore always starts on a period boundary, and no half-period ever mixes old and new values.

Top module: `dpwm_dither_top`

## Requirements
- R1: While `ch_en_i` is low, or the run length is zero (period 0, or period below 2 with dither on), the block is idle. After the next clock edge, `cnt_o` is 0, `half_o` is 0 and `pwm_o` is low, and they stay so while the block is idle.
- R2: With dither off and period P, `cnt_o` counts 0,1,…,P−1 and then returns to 0. Each such run is one full period, and `half_o` stays 0.
- R3: With dither on and period P, `cnt_o` counts 0 up to floor(P/2)−1 and then returns to 0. `half_o` encodes the half-period: 0 for the first half, 1 for the second. It toggles at every wrap, so a full period is two runs.
- R4: With dither off, `pwm_o` is high exactly when the block is running and `cnt_o` is greater than or equal to the full duty word D. It rises on the compare match and falls when the counter returns to 0.
- R5: With dither on, in the first half (`half_o`=0) the compare value is D>>1 (duty bits 10 down to 1), and `pwm_o` is high exactly when `cnt_o` ≥ D>>1.
- R6: With dither on, in the second half (`half_o`=1) the compare value is (D>>1)+D[0], and `pwm_o` is high exactly when `cnt_o` ≥ that value. With P=200 and D=31 this gives 85 high counts, then 84 high counts, and four edges per period.
- R7: A compare value of 0 keeps `pwm_o` high for the whole run. A compare value at or above the run length keeps `pwm_o` low for the whole run.
- R8: Changes to `per_i`, `duty_i` and `dith_en_i` made while running take effect only after the current full period ends. The first period after leaving idle uses the values present at that edge.
- R9: On the first clock edge at which the block leaves idle, the counter starts at 0 in the first half-period, and `pwm_o` is high only if the compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_en_i | input | 1 | Channel enable |
| dith_en_i | input | 1 | Dither enable (change only while idle) |
| per_i | input | 11 | Period word P |
| duty_i | input | 11 | Duty word D |
| pwm_o | output | 1 | PWM output |
| cnt_o | output | 11 | Current timebase count |
| half_o | output | 1 | Half-period indicator (0 first, 1 second) |

## Verification
Two events can fall on the same clock edge: the counter wrap that clears the output, and a compare match that sets it. They coincide when the compare value is 0, and again at a full-period boundary, where the shadow load also changes the compare value. The bench provokes this with zero duty words, with duty words of 1 in dither mode (0 in the first half, 1 in the second), and with mid-period rewrites of the period and duty words that become visible only at the wrap. Every cycle it compares the output against a model in which the output is high exactly when the count is at or above the compare value latched for the current half.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  // Default width of the period and duty words
  localparam int unsigned DPWM_DEF_W = 11;

  // Half-period encoding; also the value of half_o
  typedef enum logic {
    HALF_A = 1'b0,
    HALF_B = 1'b1
  } half_e;

endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow
  import dpwm_pkg::*;
#(
  parameter int unsigned W = DPWM_DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  input  logic         dith_i,
  output logic [W-1:0] per_q_o,
  output logic [W-1:0] duty_q_o,
  output logic         dith_q_o,
  output logic [W-1:0] per_d_o,
  output logic [W-1:0] duty_d_o,
  output logic         dith_d_o
);

  logic [W-1:0] per_q, duty_q;
  logic         dith_q;

  // Values the shadow will hold after the coming edge
  assign per_d_o  = load_i ? per_i  : per_q;
  assign duty_d_o = load_i ? duty_i : duty_q;
  assign dith_d_o = load_i ? dith_i : dith_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      dith_q <= 1'b0;
    end else begin
      per_q  <= per_d_o;
      duty_q <= duty_d_o;
      dith_q <= dith_d_o;
    end
  end

  assign per_q_o  = per_q;
  assign duty_q_o = duty_q;
  assign dith_q_o = dith_q;

endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
  import dpwm_pkg::*;
#(
  parameter int unsigned W = DPWM_DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         idle_i,
  input  logic [W-1:0] per_q_i,
  input  logic         dith_q_i,
  output logic [W-1:0] cnt_o,
  output logic         half_o,
  output logic         run_o,
  output logic [W-1:0] cnt_d_o,
  output logic         half_d_o,
  output logic         full_wrap_o,
  output logic         load_o
);

  localparam logic [W-1:0] ONE = W'(1);

  // Length of one counter run: half the period when dithering
  function automatic logic [W-1:0] run_len(input logic [W-1:0] per, input logic dith);
    return dith ? {1'b0, per[W-1:1]} : per;
  endfunction

  logic [W-1:0] cnt_q, cnt_d, lim_w;
  half_e        half_q, half_d;
  logic         run_q;
  logic         term_w;

  assign lim_w       = run_len(per_q_i, dith_q_i);
  assign term_w      = run_q && (cnt_q == lim_w - ONE);
  assign full_wrap_o = term_w && (!dith_q_i || (half_q == HALF_B));
  assign load_o      = idle_i || !run_q || full_wrap_o;

  always_comb begin
    cnt_d  = cnt_q + ONE;
    half_d = half_q;
    if (idle_i || !run_q) begin
      cnt_d  = '0;
      half_d = HALF_A;
    end else if (term_w) begin
      cnt_d = '0;
      if (dith_q_i) half_d = (half_q == HALF_A) ? HALF_B : HALF_A;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= HALF_A;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      run_q  <= !idle_i;
    end
  end

  assign cnt_o    = cnt_q;
  assign half_o   = (half_q == HALF_B);
  assign run_o    = run_q;
  assign cnt_d_o  = cnt_d;
  assign half_d_o = (half_d == HALF_B);

  // R2 / R3: the count never reaches the run length
  a_r2_below_limit : assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < lim_w));

  // R3: every wrap in dither mode flips the half indicator
  a_r3_half_flip : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_w && dith_q_i && !idle_i) |=> (half_q != $past(half_q)));

  // R2: no second half without dither
  a_r2_single_half : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !dith_q_i) |-> (half_q == HALF_A));

  // R1: idle parks the timebase
  a_r1_idle_park : assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (cnt_q == '0 && half_q == HALF_A && !run_q));

  // R9: the first running state starts at count 0
  a_r9_first_count : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !idle_i) |=> (run_q && cnt_q == '0 && half_q == HALF_A));

endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare
  import dpwm_pkg::*;
#(
  parameter int unsigned W = DPWM_DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         idle_i,
  input  logic         run_i,
  input  logic [W-1:0] cnt_i,
  input  logic         half_i,
  input  logic [W-1:0] duty_i,
  input  logic         dith_i,
  input  logic [W-1:0] cnt_d_i,
  input  logic         half_d_i,
  input  logic [W-1:0] duty_d_i,
  input  logic         dith_d_i,
  output logic         pwm_o
);

  // Compare value: whole duty, or its upper bits plus the low bit in half B
  function automatic logic [W-1:0] cmp_of(input logic [W-1:0] duty,
                                          input logic dith, input logic half);
    logic [W-1:0] extra;
    extra = {{(W-1){1'b0}}, half & duty[0]};
    return dith ? ({1'b0, duty[W-1:1]} + extra) : duty;
  endfunction

  logic [W-1:0] cmp_d, cmp_now;
  logic         set_w, clr_w, pwm_q, pwm_d;

  assign cmp_d   = cmp_of(duty_d_i, dith_d_i, half_d_i);
  assign cmp_now = cmp_of(duty_i, dith_i, half_i);

  // Set on match has priority over clear on wrap (covers compare value 0)
  assign set_w = (cnt_d_i == cmp_d);
  assign clr_w = (cnt_d_i == '0);

  always_comb begin
    pwm_d = pwm_q;
    if (idle_i)     pwm_d = 1'b0;
    else if (set_w) pwm_d = 1'b1;
    else if (clr_w) pwm_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_o = pwm_q;

  // R5 / R6: output is high whenever the count sits on the compare value
  a_r5_high_at_match : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == cmp_now) |-> pwm_q);

  // R4: output is low at the start of a run unless the compare value is 0
  a_r4_low_at_start : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == '0 && cmp_now != '0) |-> !pwm_q);

  // R7: a compare value of 0 holds the output high
  a_r7_zero_cmp_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cmp_now == '0) |-> pwm_q);

  // R1: never high while not running
  a_r1_idle_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_q);

endmodule

// File: rtl/dpwm_dither_top.sv
module dpwm_dither_top
  import dpwm_pkg::*;
#(
  parameter int unsigned W = DPWM_DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ch_en_i,
  input  logic         dith_en_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] duty_i,
  output logic         pwm_o,
  output logic [W-1:0] cnt_o,
  output logic         half_o
);

  // A run length of zero cannot produce a waveform
  function automatic logic len_zero(input logic [W-1:0] per, input logic dith);
    return dith ? (per[W-1:1] == '0) : (per == '0);
  endfunction

  logic         idle_w, run_w, load_w, full_wrap_w;
  logic [W-1:0] per_sh, duty_sh, per_nx, duty_nx, cnt_nx;
  logic         dith_sh, dith_nx, half_nx, half_w;

  assign idle_w = !ch_en_i || len_zero(per_i, dith_en_i);

  dpwm_shadow #(.W(W)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_w),
    .per_i    (per_i),
    .duty_i   (duty_i),
    .dith_i   (dith_en_i),
    .per_q_o  (per_sh),
    .duty_q_o (duty_sh),
    .dith_q_o (dith_sh),
    .per_d_o  (per_nx),
    .duty_d_o (duty_nx),
    .dith_d_o (dith_nx)
  );

  dpwm_timebase #(.W(W)) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (idle_w),
    .per_q_i     (per_sh),
    .dith_q_i    (dith_sh),
    .cnt_o       (cnt_o),
    .half_o      (half_w),
    .run_o       (run_w),
    .cnt_d_o     (cnt_nx),
    .half_d_o    (half_nx),
    .full_wrap_o (full_wrap_w),
    .load_o      (load_w)
  );

  dpwm_compare #(.W(W)) u_compare (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idle_i   (idle_w),
    .run_i    (run_w),
    .cnt_i    (cnt_o),
    .half_i   (half_w),
    .duty_i   (duty_sh),
    .dith_i   (dith_sh),
    .cnt_d_i  (cnt_nx),
    .half_d_i (half_nx),
    .duty_d_i (duty_nx),
    .dith_d_i (dith_nx),
    .pwm_o    (pwm_o)
  );

  assign half_o = half_w;

  // R8: settings stay frozen inside a period while running
  a_r8_shadow_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w && !full_wrap_w && !idle_w) |=>
      ($stable(per_sh) && $stable(duty_sh) && $stable(dith_sh)));

  // R8: a full-period wrap loads the inputs present at that edge
  a_r8_load_at_wrap : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_wrap_w && !idle_w) |=> (per_sh == $past(per_i) && duty_sh == $past(duty_i)));

  // R1: dropping the enable parks the output low
  a_r1_disable_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ch_en_i |=> (!pwm_o && cnt_o == '0 && !half_o));

endmodule

// File: tb/test_dpwm_dither_top.sv
module test_dpwm_dither_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, dith = 1'b0;
  logic [10:0] per = '0, duty = '0;
  logic        pwm, half;
  logic [10:0] cnt;

  always #10 clk = ~clk;

  dpwm_dither_top #(.W(11)) i_dpwm_dither_top (
    .clk_i(clk), .rst_ni(rst_n), .ch_en_i(en), .dith_en_i(dith),
    .per_i(per), .duty_i(duty), .pwm_o(pwm), .cnt_o(cnt), .half_o(half)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // Reference model state
  int  m_cnt = 0, m_half = 0, m_run = 0;
  int  m_per = 0, m_duty = 0, m_dith = 0;
  // Statistics over a window
  int  hi0, hi1, edges, max_cnt, prev_pwm;
  string phase = "init";

  function automatic int f_len(int p, int d);
    return d ? p / 2 : p;
  endfunction

  function automatic int f_cmp(int du, int d, int h);
    if (!d) return du;
    return du / 2 + ((h != 0) ? du % 2 : 0);
  endfunction

  task automatic check_eq(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s [%s]: actual %0d expected %0d", tag, what, phase, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    end
  endtask

  task automatic model_step();
    int idle;
    idle = (!en) || (f_len(int'(per), int'(dith)) == 0);
    if (idle || !m_run) begin
      m_run  = idle ? 0 : 1;
      m_cnt  = 0;
      m_half = 0;
      m_per = int'(per); m_duty = int'(duty); m_dith = int'(dith);
    end else if (m_cnt == f_len(m_per, m_dith) - 1) begin
      int full;
      m_cnt = 0;
      full  = 1;
      if (m_dith) begin
        full   = m_half;
        m_half = m_half ? 0 : 1;
      end
      if (full) begin
        m_per = int'(per); m_duty = int'(duty); m_dith = int'(dith);
      end
    end else begin
      m_cnt++;
    end
  endtask

  // One clock: model advances with the inputs the edge will see, then compare
  task automatic tick();
    int ep;
    string tc, tp;
    model_step();
    @(posedge clk);
    @(negedge clk);
    ep = (m_run != 0) && (m_cnt >= f_cmp(m_duty, m_dith, m_half));
    tc = !m_run ? "R1" : (m_dith ? "R3" : "R2");
    tp = !m_run ? "R1" : (m_dith ? (m_half ? "R6" : "R5") : "R4");
    check_eq(tc, "cnt", int'(cnt), m_cnt);
    check_eq(m_run ? "R3" : "R1", "half", int'(half), m_half);
    check_eq(tp, "pwm", int'(pwm), ep);
    if (m_half) hi1 += int'(pwm); else hi0 += int'(pwm);
    if (int'(pwm) != prev_pwm) edges++;
    prev_pwm = int'(pwm);
    if (int'(cnt) > max_cnt) max_cnt = int'(cnt);
  endtask

  task automatic clr_stats();
    hi0 = 0; hi1 = 0; edges = 0; max_cnt = 0; prev_pwm = int'(pwm);
  endtask

  task automatic go_idle();
    en = 1'b0;
    tick();
    tick();
  endtask

  // Leave idle with the given settings and check the first running state
  task automatic start(int p, int d, int di);
    per = 11'(p); duty = 11'(d); dith = di[0];
    en = 1'b1;
    clr_stats();
    tick();
    check_eq("R9", "first cnt", int'(cnt), 0);
    check_eq("R9", "first half", int'(half), 0);
    check_eq("R9", "first pwm", int'(pwm), (f_cmp(d, di, 0) == 0) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    phase = "reset";
    check_eq("R1", "reset cnt", int'(cnt), 0);
    check_eq("R1", "reset half", int'(half), 0);
    check_eq("R1", "reset pwm", int'(pwm), 0);
    rst_n = 1'b1;
    go_idle();

    // Dither example: P=200, D=31
    phase = "R6 dither 200/31";
    start(200, 31, 1);
    repeat (200) tick();
    check_eq("R5", "first-half high count", hi0, 85);
    check_eq("R6", "second-half high count", hi1, 84);
    check_eq("R6", "edges per period", edges, 4);
    check_eq("R3", "max count", max_cnt, 99);
    go_idle();

    // Dither with D=1: compare 0 then 1
    phase = "R7 dither duty 1";
    start(20, 1, 1);
    repeat (19) tick();
    check_eq("R7", "zero-compare half high", hi0, 10);
    check_eq("R6", "second half high", hi1, 9);
    go_idle();

    // Duty 0 without dither: always high
    phase = "R7 duty zero";
    start(50, 0, 0);
    repeat (49) tick();
    check_eq("R7", "high count", hi0, 50);
    go_idle();

    // Compare at run length: always low
    phase = "R7 duty full";
    start(20, 40, 0);
    repeat (39) tick();
    check_eq("R7", "high count no dither", hi0, 0);
    go_idle();
    start(20, 20, 1);
    repeat (39) tick();
    check_eq("R7", "high count dither", hi0 + hi1, 0);
    go_idle();

    // Small plain period
    phase = "R2 plain 7/3";
    start(7, 3, 0);
    repeat (6) tick();
    check_eq("R2", "max count", max_cnt, 6);
    check_eq("R4", "high count", hi0, 4);
    tick();
    check_eq("R2", "wrap count", int'(cnt), 0);

    // Mid-period rewrite must wait for the wrap
    phase = "R8 shadow";
    go_idle();
    start(40, 10, 0);
    repeat (5) tick();
    per = 11'd20; duty = 11'd30;
    repeat (34) tick();
    check_eq("R8", "old period still running", max_cnt, 39);
    check_eq("R8", "old duty high count", hi0, 30);
    clr_stats();
    repeat (20) tick();
    check_eq("R8", "new period max", max_cnt, 19);
    check_eq("R8", "new duty high count", hi0, 0);

    // Disable mid-run
    phase = "R1 disable";
    en = 1'b0;
    tick();
    check_eq("R1", "cnt after disable", int'(cnt), 0);
    check_eq("R1", "pwm after disable", int'(pwm), 0);
    // Period 1 with dither is idle
    per = 11'd1; dith = 1'b1; en = 1'b1;
    clr_stats();
    repeat (10) tick();
    check_eq("R1", "period-1 dither max count", max_cnt, 0);
    check_eq("R1", "period-1 dither high", hi0 + hi1, 0);
    go_idle();

    // Random segments
    phase = "random";
    for (int s = 0; s < 60; s++) begin
      int nc;
      en = 1'b0;
      tick();
      dith = 1'($urandom_range(0, 1));
      per  = 11'($urandom_range(0, 80));
      if (dith) per[0] = 1'b0;
      duty = 11'($urandom_range(0, int'(per) + 4));
      en   = ($urandom_range(0, 9) != 0);
      nc   = int'($urandom_range(50, 300));
      for (int c = 0; c < nc; c++) begin
        if ($urandom_range(0, 36) == 0) begin
          per = 11'($urandom_range(0, 80));
          if (dith) per[0] = 1'b0;
        end
        if ($urandom_range(0, 20) == 0) duty = 11'($urandom_range(0, int'(per) + 4));
        if ($urandom_range(0, 150) == 0) en = ~en;
        tick();
      end
    end

    report();
    $finish;
  end

endmodule